// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small 8-bit CPU core and decides which event-type interrupt the core should take next. Every source has a sticky pending flag and its own enable bit. A single global enable gates all of them. When the core can accept an interrupt and at least one enabled flag is pending, the controller raises a request. With that request it presents the program-memory vector of the winning source. The winner is the enabled pending source with the lowest index. Vector slot zero of the table is kept for reset, so source k sits at base + (k+1) * VEC_STEP.

The request and the acknowledge behave as a valid/ready pair. The request stays high for as long as its conditions hold. The vector always shows the source that is winning in the current cycle, and an acknowledge takes that source in that same cycle. On that edge the hardware clears the served flag and the global enable. Software may set the global enable again inside a handler, which lets any enabled source preempt that handler. A return-from-interrupt strobe also sets the global enable. Software reaches the flags, the enables and a control word through a one-cycle register write port. Flags are cleared by writing a one to them. The control word holds the global enable and a bit that moves the table base to a second boot-section address.

Top module: `intc_vectored`

## Requirements
- R1: After reset the flags, the enables, the global enable and the vector-select bit are all 0, and irq_req_o is low.
- R2: A 1 on src_evt_i[k] sets flag k at the next clock edge. The flag stays set while enable k or the global enable is 0, and it is served once both become 1.
- R3: irq_req_o is 1 exactly when cpu_ready_i, the global enable and at least one pair of set flag and set enable are all 1.
- R4: The winning source is the lowest-indexed source whose flag and enable are both 1.
- R5: irq_vec_o equals base + (k+1)*VEC_STEP for winner k. The base is 0 when the vector-select bit is 0 and ALT_BASE when it is 1.
- R6: An acknowledge during a request (irq_ack_i=1 while irq_req_o=1) clears the global enable and the winner's flag at that edge. Other flags are left as they were.
- R7: A pulse on reti_i sets the global enable at the next edge, unless an acknowledge is accepted in the same cycle.
- R8: A write with wr_sel_i=0 clears every flag whose bit in wr_data_i is 1 and leaves the other flags alone. wr_sel_i=1 loads the enables from wr_data_i. wr_sel_i=2 loads the global enable from wr_data_i bit 0 and the vector-select bit from wr_data_i bit 1.
- R9: If a source event lands on the same cycle as a clear of its flag (a write-one-to-clear or an acknowledge), the flag stays set.
- R10: After entry, a software write that sets the global enable lets any enabled pending source raise a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | N_SRC | Event pulses, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 flag clear, 1 enables, 2 control |
| wr_data_i | input | N_SRC | Write data |
| cpu_ready_i | input | 1 | The core can accept an interrupt |
| irq_req_o | output | 1 | Interrupt request (valid) |
| irq_vec_o | output | ADDR_W | Vector of the current winner |
| irq_ack_i | input | 1 | Core takes the request (ready) |
| reti_i | input | 1 | Return-from-interrupt strobe |
| flags_o | output | N_SRC | Pending flags |
| enables_o | output | N_SRC | Per-source enables |
| gie_o | output | 1 | Global enable |
| vsel_o | output | 1 | Vector table select |

## Verification
A wrong flag or enable shows on the ports one cycle after the stimulus, either on flags_o or as a request with the wrong vector. A global enable that fails to clear on entry shows as a second request in the cycle right after the acknowledge. A global enable that fails to come back shows as a missing request after reti. A wrong priority or base shows on irq_vec_o as soon as two enabled sources are pending together.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    WSEL_FLAG_CLR = 2'd0,
    WSEL_ENABLE   = 2'd1,
    WSEL_CTRL     = 2'd2
  } wsel_e;

  localparam int CTRL_GIE_BIT  = 0;
  localparam int CTRL_VSEL_BIT = 1;
endpackage

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] flags_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;   // a new event beats any clear
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o    = |req_i;
    onehot_o = any_o ? (N_SRC'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/intc_vec_gen.sv
module intc_vec_gen #(
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 16,
  parameter int VEC_STEP = 2,
  parameter int ALT_BASE = 16'h1C00
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              vsel_i,
  output logic [ADDR_W-1:0] vec_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] slot;

  always_comb begin
    base  = vsel_i ? ADDR_W'(ALT_BASE) : '0;
    slot  = ADDR_W'(idx_i) + ADDR_W'(1);   // slot 0 belongs to reset
    vec_o = base + slot * ADDR_W'(VEC_STEP);
  end
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored #(
  parameter int N_SRC    = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_STEP = 2,
  parameter int ALT_BASE = 16'h1C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  input  logic              cpu_ready_i,
  output logic              irq_req_o,
  output logic [ADDR_W-1:0] irq_vec_o,
  input  logic              irq_ack_i,
  input  logic              reti_i,
  output logic [N_SRC-1:0]  flags_o,
  output logic [N_SRC-1:0]  enables_o,
  output logic              gie_o,
  output logic              vsel_o
);
  import intc_pkg::*;

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  wsel_e            wsel;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] win_oh;
  logic [N_SRC-1:0] flag_clr;
  logic [IDX_W-1:0] win_idx;
  logic             any_pend;
  logic             accept;
  logic             wr_flag, wr_en_reg, wr_ctrl;

  assign wsel      = wsel_e'(wr_sel_i);
  assign wr_flag   = wr_en_i && (wsel == WSEL_FLAG_CLR);
  assign wr_en_reg = wr_en_i && (wsel == WSEL_ENABLE);
  assign wr_ctrl   = wr_en_i && (wsel == WSEL_CTRL);

  assign pend      = flags_o & enables_o;
  assign irq_req_o = cpu_ready_i && gie_o && any_pend;
  assign accept    = irq_req_o && irq_ack_i;
  assign flag_clr  = (wr_flag ? wr_data_i : '0) | (accept ? win_oh : '0);

  intc_flag_bank #(.N_SRC(N_SRC)) flag_bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (src_evt_i),
    .clr_i   (flag_clr),
    .flags_o (flags_o)
  );

  intc_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) prio_i (
    .req_i    (pend),
    .any_o    (any_pend),
    .idx_o    (win_idx),
    .onehot_o (win_oh)
  );

  intc_vec_gen #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_STEP(VEC_STEP), .ALT_BASE(ALT_BASE)
  ) vec_i (
    .idx_i  (win_idx),
    .vsel_i (vsel_o),
    .vec_o  (irq_vec_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enables_o <= '0;
      vsel_o    <= 1'b0;
    end else begin
      if (wr_en_reg) enables_o <= wr_data_i;
      if (wr_ctrl)   vsel_o    <= wr_data_i[CTRL_VSEL_BIT];
    end
  end

  // entry beats return, return beats a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_o <= 1'b0;
    else if (accept)  gie_o <= 1'b0;
    else if (reti_i)  gie_o <= 1'b1;
    else if (wr_ctrl) gie_o <= wr_data_i[CTRL_GIE_BIT];
  end
endmodule

// File: rtl/intc_vectored_chk.sv
module intc_vectored_chk #(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_evt_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [N_SRC-1:0]  wr_data_i,
  input logic              cpu_ready_i,
  input logic              irq_req_o,
  input logic [ADDR_W-1:0] irq_vec_o,
  input logic              irq_ack_i,
  input logic              reti_i,
  input logic [N_SRC-1:0]  flags_o,
  input logic [N_SRC-1:0]  enables_o,
  input logic              gie_o,
  input logic              vsel_o
);
  // R3
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (cpu_ready_i && gie_o && ((flags_o & enables_o) != '0)));

  // R6
  entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i) |=> !gie_o);

  // R7
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !(irq_req_o && irq_ack_i)) |=> gie_o);

  // R2
  event_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt_i != '0) |=> ((flags_o & $past(src_evt_i)) == $past(src_evt_i)));

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0 && src_evt_i == '0) |=> ((flags_o & $past(wr_data_i)) == '0));
endmodule

bind intc_vectored intc_vectored_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/intc_vectored_tb_top.sv
module intc_vectored_tb_top;
  localparam int N        = 8;
  localparam int AW       = 16;
  localparam int STEP     = 2;
  localparam int ALT      = 16'h1C00;
  localparam int NV       = 6;

  localparam logic [N-1:0] TV_EN  [NV] = '{8'hFF, 8'hF0, 8'hFF, 8'h7E, 8'h01, 8'hC0};
  localparam logic [N-1:0] TV_EVT [NV] = '{8'h28, 8'h0F, 8'h80, 8'h03, 8'h01, 8'hF0};
  localparam logic         TV_VS  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [N-1:0] wr_data = '0;
  logic cpu_ready = 1'b1;
  logic irq_req, irq_ack = 1'b0, reti = 1'b0;
  logic [AW-1:0] irq_vec;
  logic [N-1:0] flags, enables;
  logic gie, vsel;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  intc_vectored #(.N_SRC(N), .ADDR_W(AW), .VEC_STEP(STEP), .ALT_BASE(ALT)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cpu_ready_i(cpu_ready), .irq_req_o(irq_req), .irq_vec_o(irq_vec),
    .irq_ack_i(irq_ack), .reti_i(reti), .flags_o(flags), .enables_o(enables),
    .gie_o(gie), .vsel_o(vsel)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_evt(input logic [N-1:0] e);
    src_evt = e;
    tick();
    src_evt = '0;
  endtask

  task automatic ack_once();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic reti_once();
    reti = 1'b1;
    tick();
    reti = 1'b0;
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int exp_vec(input int k, input logic vs);
    return (vs ? ALT : 0) + (k + 1) * STEP;
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk(flags == 0 && enables == 0 && !gie && !vsel && !irq_req, "R1",
        {flags, enables, 6'd0, gie, vsel}, 0);
    rst_n = 1'b1;
    tick();

    // vector table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int k;
      wr(2'd1, TV_EN[v]);
      wr(2'd2, {6'd0, TV_VS[v], 1'b1});
      pulse_evt(TV_EVT[v]);
      k = lowest(TV_EVT[v] & TV_EN[v]);
      if (k < 0) begin
        chk(!irq_req, "R3", irq_req, 0);
      end else begin
        chk(irq_req, "R3", irq_req, 1);
        chk(irq_vec == AW'(exp_vec(k, TV_VS[v])), "R4/R5", irq_vec, exp_vec(k, TV_VS[v]));
        ack_once();
        chk(!gie, "R6 gie", gie, 0);
        chk(flags == (TV_EVT[v] & ~(N'(1) << k)), "R6 flag", flags, TV_EVT[v] & ~(N'(1) << k));
        reti_once();
        chk(gie, "R7", gie, 1);
      end
      wr(2'd0, '1);
      chk(flags == 0, "R8 clear all", flags, 0);
    end

    // R2 sticky while global enable is 0, served after enabling
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h00);
    pulse_evt(8'h10);
    chk(flags == 8'h10 && !irq_req, "R2 held", {flags, 7'd0, irq_req}, 16'h1000);
    wr(2'd2, 8'h01);
    chk(irq_req && irq_vec == AW'(exp_vec(4, 1'b0)), "R2 served", irq_vec, exp_vec(4, 1'b0));
    ack_once();
    chk(flags == 0, "R6 single", flags, 0);
    reti_once();

    // R8 partial write-one-to-clear, zeros leave flags alone
    wr(2'd1, 8'h00);
    pulse_evt(8'h0F);
    wr(2'd0, 8'h05);
    chk(flags == 8'h0A, "R8 partial", flags, 8'h0A);

    // R9 event and clear in the same cycle
    src_evt = 8'h02;
    wr(2'd0, 8'h02);
    src_evt = '0;
    chk(flags == 8'h0A, "R9 w1c", flags, 8'h0A);
    wr(2'd0, '1);

    // R3 cpu_ready gates the request
    wr(2'd1, 8'hFF);
    pulse_evt(8'h04);
    cpu_ready = 1'b0;
    #1;
    chk(!irq_req, "R3 not ready", irq_req, 0);
    cpu_ready = 1'b1;
    #1;
    chk(irq_req, "R3 ready", irq_req, 1);

    // R9 acknowledge with a same-source event
    src_evt = 8'h04;
    ack_once();
    src_evt = '0;
    chk(flags == 8'h04 && !gie, "R9 ack", flags, 8'h04);
    wr(2'd0, '1);

    // R10 nesting: handler re-enables, a new source preempts
    reti_once();
    pulse_evt(8'h20);
    ack_once();
    pulse_evt(8'h04);
    chk(!irq_req, "R10 blocked", irq_req, 0);
    wr(2'd2, 8'h01);
    chk(irq_req && irq_vec == AW'(exp_vec(2, 1'b0)), "R10 nested", irq_vec, exp_vec(2, 1'b0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule